// File: doc/BRIEF.md
# Remapping-unit global command and status registers

This block holds the global control state of an interrupt-remapping unit. Software writes a 32-bit command word to turn persistent features on or off, or to start one-shot operations. A 32-bit status word shows the state that results. A separate 64-bit register holds the page-aligned base of the remapping table, a size code and an extended-mode enable. The register bus is a single-beat, 32-bit interface. Every request gets an acknowledge and read data on the next cycle.

A command write is compared against the current status with the one-shot positions removed. A write that changes nothing is dropped. A write that changes several fields at once is still carried out, and it raises a multi-field flag. Writing the table-pointer command starts a handshake. Status bit 24 drops and a busy output rises. After a programmable number of cycles, the table base, entry count and extended-mode flag are latched from the value the address register held at the command. Status bit 24 then returns.

Top module: `irq_remap_gcs`

## Requirements
- R1: After reset the status word, the address register, the latched page, the entry count, the extended flag, the multi-field flag, busy, acknowledge and read data are all zero.
- R2: The address register is written and read as two aligned words, low at offset 0xB8 and high at 0xBC. It stores only the page bits [PA_W-1:12], the extended-mode enable at bit 11 and the size code at bits 3:0. With the default PA_W of 48, writing all ones to the low word reads back 0xFFFFF80F and writing all ones to the high word reads back 0x0000FFFF.
- R3: The command register is at offset 0x18 and the status register at 0x1C. On an effective command write, the persistent status bits 31, 28, 26, 25 and 23 take the written values. Bit 31 also drives `xlate_en_o` and bit 25 drives `remap_en_o`.
- R4: The change set is (status AND 0x96FFFFFF) XOR written word. Bits 30, 29, 27 and 24 are one-shot positions and never count as current state. A command write whose change set is zero alters neither the status word nor the multi-field flag.
- R5: On an effective command write, `multi_o` becomes 1 if the change set has two or more bits set, and 0 if it has exactly one. Otherwise it holds its value.
- R6: A command write with bit 24 set clears status bit 24 and raises `busy_o` from the next cycle, for exactly LATENCY cycles (1 to 8, default 3). Then busy falls and status bit 24 is set. It stays set until the next such command.
- R7: At completion, the latched page equals address bits [PA_W-1:12] and the entry count equals 2^(S+1), where S is bits 3:0. The extended flag equals bit 11. All three are taken from the address register as it stood at the command write.
- R8: The latched page, entry count and extended flag update only if the new page or entry count differs from the latched values. A command that changes only bit 11 leaves `tbl_ext_o` unchanged, yet still completes the handshake.
- R9: A request whose address has bits 1:0 non-zero is ignored. A write changes no register. A read returns 0. Both still receive `acc_ack` on the next cycle.
- R10: Reads of the command offset return 0. Writes to the status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Single-cycle access request |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_ack | output | 1 | Completion, one cycle after the request |
| acc_rdata | output | 32 | Read data, valid with acc_ack |
| xlate_en_o | output | 1 | Status bit 31 |
| remap_en_o | output | 1 | Status bit 25 |
| busy_o | output | 1 | Table-pointer handshake in progress |
| multi_o | output | 1 | Last effective command changed several fields |
| tbl_page_o | output | PA_W-12 | Latched table page number |
| tbl_entries_o | output | 17 | Latched entry count |
| tbl_ext_o | output | 1 | Latched extended-mode flag |

## Verification
The hardest case to reach is a repeated pointer command that skips the latch update while the handshake still runs. Reaching it needs a first latch with a known page and size. The bench then changes only the extended-mode bit and issues the command again. It observes that busy and status bit 24 still cycle while `tbl_ext_o` keeps its old value, and then changes the size to show that an update does occur. A table of command words walks the status through no-op writes, single-field writes, multi-field writes and one-shot-only writes. After each step it checks both the status word and the multi-field flag.

// File: rtl/irgcs_pkg.sv
package irgcs_pkg;
   localparam int OFF_W = 8;
   localparam logic [OFF_W-1:0] OFF_CMD    = 8'h18;
   localparam logic [OFF_W-1:0] OFF_STS    = 8'h1C;
   localparam logic [OFF_W-1:0] OFF_TBL_LO = 8'hB8;
   localparam logic [OFF_W-1:0] OFF_TBL_HI = 8'hBC;

   localparam int B_TE  = 31;
   localparam int B_RTP = 30;
   localparam int B_AFL = 28;
   localparam int B_WBF = 27;
   localparam int B_QIE = 26;
   localparam int B_IRE = 25;
   localparam int B_PTR = 24;
   localparam int B_CFI = 23;

   // positions kept when deriving the current command from status
   localparam logic [31:0] KEEP_MASK    = 32'h96FF_FFFF;
   // positions that hold their written value
   localparam logic [31:0] PERSIST_MASK = (32'd1 << B_TE) | (32'd1 << B_AFL) |
                                          (32'd1 << B_QIE) | (32'd1 << B_IRE) |
                                          (32'd1 << B_CFI);

   localparam int EXT_BIT = 11;
   localparam int SZ_W    = 4;
   localparam int ENT_W   = (1 << SZ_W) + 1;
endpackage

// File: rtl/irgcs_decode.sv
module irgcs_decode
   import irgcs_pkg::*;
(
   input  logic             req,
   input  logic             we,
   input  logic [OFF_W-1:0] addr,
   output logic             wr_cmd,
   output logic             wr_lo,
   output logic             wr_hi,
   output logic             rd_cmd,
   output logic             rd_sts,
   output logic             rd_lo,
   output logic             rd_hi
);
   logic hit;

   always_comb begin
      hit    = req && (addr[1:0] == 2'b00);
      wr_cmd = hit &&  we && (addr == OFF_CMD);
      wr_lo  = hit &&  we && (addr == OFF_TBL_LO);
      wr_hi  = hit &&  we && (addr == OFF_TBL_HI);
      rd_cmd = hit && !we && (addr == OFF_CMD);
      rd_sts = hit && !we && (addr == OFF_STS);
      rd_lo  = hit && !we && (addr == OFF_TBL_LO);
      rd_hi  = hit && !we && (addr == OFF_TBL_HI);
   end
endmodule

// File: rtl/irgcs_tbl_reg.sv
module irgcs_tbl_reg
   import irgcs_pkg::*;
#(
   parameter int PA_W = 48,
   localparam int PG_W = PA_W - 12,
   localparam int HI_W = PA_W - 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [19:0]     lo_page_w,
   input  logic            ext_w,
   input  logic [SZ_W-1:0] size_w,
   input  logic [HI_W-1:0] hi_w,
   output logic [31:0]     lo_rd,
   output logic [31:0]     hi_rd,
   output logic [PG_W-1:0] page,
   output logic            ext,
   output logic [SZ_W-1:0] size
);
   logic [19:0]     lo_page_q;
   logic [HI_W-1:0] hi_q;
   logic            ext_q;
   logic [SZ_W-1:0] size_q;

   if (PA_W < 33 || PA_W > 64) begin : g_bad_pa
      $error("irgcs_tbl_reg: PA_W must lie in 33..64");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_page_q <= '0;
         ext_q     <= 1'b0;
         size_q    <= '0;
         hi_q      <= '0;
      end else begin
         if (wr_lo) begin
            lo_page_q <= lo_page_w;
            ext_q     <= ext_w;
            size_q    <= size_w;
         end
         if (wr_hi) hi_q <= hi_w;
      end
   end

   always_comb begin
      lo_rd = '0;
      lo_rd[31:12]     = lo_page_q;
      lo_rd[EXT_BIT]   = ext_q;
      lo_rd[SZ_W-1:0]  = size_q;
   end

   if (HI_W == 32) begin : g_hi_full
      assign hi_rd = hi_q;
   end else begin : g_hi_pad
      assign hi_rd = {{(32-HI_W){1'b0}}, hi_q};
   end

   assign page = {hi_q, lo_page_q};
   assign ext  = ext_q;
   assign size = size_q;

   // R2: a word not addressed keeps its content
   a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> $stable(hi_rd));
   a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> $stable(lo_rd));
endmodule

// File: rtl/irgcs_cmd_sts.sv
module irgcs_cmd_sts
   import irgcs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] wdata,
   input  logic        ptr_done,
   output logic [31:0] status,
   output logic        multi,
   output logic        ptr_start
);
   logic [31:0] sts_q, sts_d, kept, changed;
   logic        eff, multi_q, multi_d;

   always_comb begin
      kept      = sts_q & KEEP_MASK;
      changed   = kept ^ wdata;
      eff       = cmd_wr && (changed != '0);
      ptr_start = eff && wdata[B_PTR];
      sts_d     = sts_q;
      multi_d   = multi_q;
      if (ptr_done) sts_d[B_PTR] = 1'b1;
      if (eff) begin
         sts_d   = (sts_d & ~PERSIST_MASK) | (wdata & PERSIST_MASK);
         multi_d = (changed & (changed - 32'd1)) != '0;
         if (wdata[B_PTR]) sts_d[B_PTR] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q   <= '0;
         multi_q <= 1'b0;
      end else begin
         sts_q   <= sts_d;
         multi_q <= multi_d;
      end
   end

   assign status = sts_q;
   assign multi  = multi_q;

   // R4: a write that matches the masked status leaves everything alone
   a_r4_noop: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && ((status & KEEP_MASK) == wdata) && !ptr_done
      |=> $stable(status) && $stable(multi));
   // R3: persistent positions take the written value
   a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && ((status & KEEP_MASK) != wdata)
      |=> (status & PERSIST_MASK) == ($past(wdata) & PERSIST_MASK));
   // R6: pointer command drops the status bit
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_start |=> !status[B_PTR]);
   // R5: single-bit change clears the flag
   a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && $onehot((status & KEEP_MASK) ^ wdata) |=> !multi);
endmodule

// File: rtl/irgcs_ptr_latch.sv
module irgcs_ptr_latch
   import irgcs_pkg::*;
#(
   parameter int LATENCY = 3,
   parameter int PG_W    = 36,
   localparam int CNT_W  = $clog2(LATENCY + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PG_W-1:0]  page_i,
   input  logic             ext_i,
   input  logic [SZ_W-1:0]  size_i,
   output logic             busy,
   output logic             done,
   output logic [PG_W-1:0]  page_q,
   output logic [ENT_W-1:0] entries_q,
   output logic             ext_q
);
   logic [PG_W-1:0]  snap_page;
   logic [ENT_W-1:0] snap_ent;
   logic             snap_ext;
   logic [ENT_W-1:0] ent_of_size;

   if (LATENCY < 1 || LATENCY > 8) begin : g_bad_lat
      $error("irgcs_ptr_latch: LATENCY must lie in 1..8");
   end

   assign ent_of_size = {{(ENT_W-1){1'b0}}, 1'b1} << ({1'b0, size_i} + 1'b1);

   if (LATENCY == 1) begin : g_lat_one
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= start;
      end
      assign busy = pend_q;
      assign done = pend_q;
   end else begin : g_lat_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (start)          cnt_q <= CNT_W'(LATENCY);
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign busy = (cnt_q != '0);
      assign done = (cnt_q == CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_page <= '0;
         snap_ent  <= '0;
         snap_ext  <= 1'b0;
         page_q    <= '0;
         entries_q <= '0;
         ext_q     <= 1'b0;
      end else begin
         if (done && ((snap_page != page_q) || (snap_ent != entries_q))) begin
            page_q    <= snap_page;
            entries_q <= snap_ent;
            ext_q     <= snap_ext;
         end
         if (start) begin
            snap_page <= page_i;
            snap_ent  <= ent_of_size;
            snap_ext  <= ext_i;
         end
      end
   end

   // R8: latched fields change only on completion
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(page_q) && $stable(entries_q) && $stable(ext_q));
   // R6: completion without restart ends the busy window
   a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !busy);
   // R6: a start always opens a busy window
   a_r6_open: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/irq_remap_gcs.sv
module irq_remap_gcs
   import irgcs_pkg::*;
#(
   parameter int LATENCY = 3,
   parameter int PA_W    = 48,
   localparam int PG_W   = PA_W - 12,
   localparam int HI_W   = PA_W - 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_req,
   input  logic             acc_we,
   input  logic [OFF_W-1:0] acc_addr,
   input  logic [31:0]      acc_wdata,
   output logic             acc_ack,
   output logic [31:0]      acc_rdata,
   output logic             xlate_en_o,
   output logic             remap_en_o,
   output logic             busy_o,
   output logic             multi_o,
   output logic [PG_W-1:0]  tbl_page_o,
   output logic [ENT_W-1:0] tbl_entries_o,
   output logic             tbl_ext_o
);
   logic wr_cmd, wr_lo, wr_hi, rd_cmd, rd_sts, rd_lo, rd_hi;
   logic [31:0] status, lo_rd, hi_rd, rd_val, rdata_q;
   logic [PG_W-1:0] reg_page;
   logic reg_ext, ptr_start, ptr_done, ack_q;
   logic [SZ_W-1:0] reg_size;

   irgcs_decode u_dec (
      .req(acc_req), .we(acc_we), .addr(acc_addr),
      .wr_cmd(wr_cmd), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .rd_cmd(rd_cmd), .rd_sts(rd_sts), .rd_lo(rd_lo), .rd_hi(rd_hi)
   );

   irgcs_tbl_reg #(.PA_W(PA_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .lo_page_w(acc_wdata[31:12]), .ext_w(acc_wdata[EXT_BIT]),
      .size_w(acc_wdata[SZ_W-1:0]), .hi_w(acc_wdata[HI_W-1:0]),
      .lo_rd(lo_rd), .hi_rd(hi_rd), .page(reg_page), .ext(reg_ext), .size(reg_size)
   );

   irgcs_cmd_sts u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .wdata(acc_wdata),
      .ptr_done(ptr_done), .status(status), .multi(multi_o), .ptr_start(ptr_start)
   );

   irgcs_ptr_latch #(.LATENCY(LATENCY), .PG_W(PG_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .start(ptr_start),
      .page_i(reg_page), .ext_i(reg_ext), .size_i(reg_size),
      .busy(busy_o), .done(ptr_done),
      .page_q(tbl_page_o), .entries_q(tbl_entries_o), .ext_q(tbl_ext_o)
   );

   always_comb begin
      rd_val = '0;
      if (rd_cmd)      rd_val = '0;
      else if (rd_sts) rd_val = status;
      else if (rd_lo)  rd_val = lo_rd;
      else if (rd_hi)  rd_val = hi_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= acc_req;
         rdata_q <= rd_val;
      end
   end

   assign acc_ack    = ack_q;
   assign acc_rdata  = rdata_q;
   assign xlate_en_o = status[B_TE];
   assign remap_en_o = status[B_IRE];

   // R9: misaligned access is acknowledged with zero data
   a_r9_bad_ack: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && (acc_addr[1:0] != 2'b00) |=> acc_ack && (acc_rdata == '0));
   // R9: misaligned write touches no register
   a_r9_bad_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && acc_we && (acc_addr[1:0] != 2'b00) && !busy_o
      |=> $stable(status) && $stable(lo_rd) && $stable(hi_rd));
   // R10: status offset is read-only
   a_r10_sts_ro: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && acc_we && (acc_addr == OFF_STS) && !busy_o |=> $stable(status));
   // R6: the status bit stays low during the handshake
   a_r6_busy_hides: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !status[B_PTR]);
   // R6: end of handshake shows the status bit
   a_r6_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> status[B_PTR]);
endmodule

// File: tb/irq_remap_gcs_tb_top.sv
`timescale 1ns/1ps
module irq_remap_gcs_tb_top;
   localparam int LAT  = 3;
   localparam int PA_W = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0, acc_we = 1'b0;
   logic [7:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_ack, xlate_en_o, remap_en_o, busy_o, multi_o, tbl_ext_o;
   logic [31:0] acc_rdata;
   logic [35:0] tbl_page_o;
   logic [16:0] tbl_entries_o;

   int checks = 0, fails = 0;
   bit finished = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   irq_remap_gcs #(.LATENCY(LAT), .PA_W(PA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
      .acc_rdata(acc_rdata), .xlate_en_o(xlate_en_o), .remap_en_o(remap_en_o),
      .busy_o(busy_o), .multi_o(multi_o), .tbl_page_o(tbl_page_o),
      .tbl_entries_o(tbl_entries_o), .tbl_ext_o(tbl_ext_o)
   );

   // {expected multi, command word, expected status}
   localparam logic [64:0] VEC [8] = '{
      {1'b0, 32'h0200_0000, 32'h0200_0000},
      {1'b0, 32'h8200_0000, 32'h8200_0000},
      {1'b1, 32'h9680_0000, 32'h9680_0000},
      {1'b1, 32'h9680_0000, 32'h9680_0000},
      {1'b1, 32'h1000_0000, 32'h1000_0000},
      {1'b0, 32'h1000_0001, 32'h1000_0000},
      {1'b1, 32'h4000_0000, 32'h0000_0000},
      {1'b0, 32'h0800_0000, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_req = 1'b0;
      chk("R9 ack", {63'd0, acc_ack}, 64'd1);
      d = acc_rdata;
   endtask

   task automatic ptr_cmd_timed();
      wr(8'h18, 32'h0100_0000);
      chk("R6 busy after cmd", {63'd0, busy_o}, 64'd1);
      for (int i = 0; i < LAT - 1; i++) begin
         @(negedge clk);
         chk("R6 busy window", {63'd0, busy_o}, 64'd1);
      end
      @(negedge clk);
      chk("R6 busy end", {63'd0, busy_o}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog R1..all actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", {63'd0, busy_o}, 64'd0);
      chk("R1 multi", {63'd0, multi_o}, 64'd0);
      chk("R1 page", {28'd0, tbl_page_o}, 64'd0);
      chk("R1 entries", {47'd0, tbl_entries_o}, 64'd0);
      chk("R1 ack", {63'd0, acc_ack}, 64'd0);
      rst_n = 1'b1;
      rd(8'h1C, rv); chk("R1 status", {32'd0, rv}, 64'd0);
      rd(8'hB8, rv); chk("R1 tbl lo", {32'd0, rv}, 64'd0);

      // R3 R4 R5: command vector walk
      for (int i = 0; i < 8; i++) begin
         wr(8'h18, VEC[i][63:32]);
         chk("R5 multi vec", {63'd0, multi_o}, {63'd0, VEC[i][64]});
         rd(8'h1C, rv);
         chk("R4 status vec", {32'd0, rv}, {32'd0, VEC[i][31:0]});
      end
      wr(8'h18, 32'h8200_0000);
      chk("R3 xlate_en", {63'd0, xlate_en_o}, 64'd1);
      chk("R3 remap_en", {63'd0, remap_en_o}, 64'd1);
      wr(8'h18, 32'h0000_0000);
      chk("R3 remap_en off", {63'd0, remap_en_o}, 64'd0);

      // R10: command reads zero, status write ignored
      rd(8'h18, rv); chk("R10 cmd read", {32'd0, rv}, 64'd0);
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h1C, rv); chk("R10 sts write", {32'd0, rv}, 64'd0);

      // R2: implemented bits of the address register
      wr(8'hB8, 32'hFFFF_FFFF);
      rd(8'hB8, rv); chk("R2 lo mask", {32'd0, rv}, 64'hFFFF_F80F);
      wr(8'hBC, 32'hFFFF_FFFF);
      rd(8'hBC, rv); chk("R2 hi mask", {32'd0, rv}, 64'h0000_FFFF);
      wr(8'hB8, 32'h0000_5803);
      wr(8'hBC, 32'h0000_1234);
      rd(8'hB8, rv); chk("R2 lo value", {32'd0, rv}, 64'h5803);

      // R6 R7: pointer handshake
      wr(8'h18, 32'h0100_0000);
      rd(8'h1C, rv); chk("R6 status bit low", {32'd0, rv}, 64'd0);
      chk("R7 entries held during busy", {47'd0, tbl_entries_o}, 64'd0);
      repeat (LAT) @(negedge clk);
      chk("R6 idle", {63'd0, busy_o}, 64'd0);
      rd(8'h1C, rv); chk("R6 status bit set", {32'd0, rv}, 64'h0100_0000);
      chk("R7 page", {28'd0, tbl_page_o}, 64'h1234_00005);
      chk("R7 entries", {47'd0, tbl_entries_o}, 64'd16);
      chk("R7 ext", {63'd0, tbl_ext_o}, 64'd1);

      // R6: exact busy window length
      wr(8'hB8, 32'h0000_5003);
      ptr_cmd_timed();
      // R8: only ext changed -> no update
      chk("R8 ext kept", {63'd0, tbl_ext_o}, 64'd1);
      chk("R8 entries kept", {47'd0, tbl_entries_o}, 64'd16);
      rd(8'h1C, rv); chk("R8 handshake done", {32'd0, rv}, 64'h0100_0000);
      // R8: size change -> update
      wr(8'hB8, 32'h0000_5007);
      ptr_cmd_timed();
      chk("R8 entries updated", {47'd0, tbl_entries_o}, 64'd256);
      chk("R8 ext updated", {63'd0, tbl_ext_o}, 64'd0);
      // R7: snapshot at command time, later write not used
      wr(8'hB8, 32'h0000_600F);
      wr(8'h18, 32'h0100_0000);
      wr(8'hB8, 32'h0000_7000);
      repeat (LAT) @(negedge clk);
      chk("R7 snapshot page", {28'd0, tbl_page_o}, 64'h1234_00006);
      chk("R7 snapshot entries", {47'd0, tbl_entries_o}, 64'd65536);

      // R9: misaligned accesses
      wr(8'hB9, 32'hFFFF_FFFF);
      rd(8'hB8, rv); chk("R9 bad write lo", {32'd0, rv}, 64'h7000);
      wr(8'h19, 32'h0200_0000);
      chk("R9 bad cmd write", {63'd0, remap_en_o}, 64'd0);
      chk("R9 bad cmd busy", {63'd0, busy_o}, 64'd0);
      rd(8'h1D, rv); chk("R9 bad read", {32'd0, rv}, 64'd0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule